// File: doc/BRIEF.md
# Multi-port I2C hub repeater

This block repeats an I2C SDA line and an I2C SCL line across five bus segments. Any segment can talk to any other, there is no direction control, and the delay between segments is that of a single repeater. Each segment connects through an open-drain pull-down output and a sampled input. The input reports whether a device on that segment pulls the line below the low level that the hub itself drives. The hub's own pull-down therefore never looks like an outside holder, and this is what keeps the repeater free of lock-up. SDA and SCL use identical, independent copies of the same logic.

Each signal also has a pair of shared, active-low, open-drain lines for clustering several hubs into one wider hub. The busy line falls whenever any enabled segment is low. The held line falls only while some segment is pulled low by an outside device. When the outside lows are released, the hub lets them go in a fixed order:

1. The held line is released first.
2. The segment whose outside holder let go last is then released.
3. The busy line is released next, once that segment reads high or a rise timeout has run out.
4. Only after both shared lines are high are the other segments released.

Segments 1 to 4 each have an enable. Segment 0 is always active.

Top module: `i2c_hub_rpt`

## Requirements
- R1: After reset, no segment pull-down and no shared-line pull-down is asserted.
- R2: When an enabled segment input reads low (0 = an outside device pulls it low), the hub pulls both of that signal's shared lines low (bit 0 = busy, bit 1 = held) and drives every enabled segment of that signal low.
- R3: `port_en[i]` = 1 enables segment i for i = 1..4. A disabled segment's inputs are ignored and its pull-downs are never asserted.
- R4: The held pull-down is asserted only while some segment is outside-held. It is deasserted once the last outside holder lets go, and it is never asserted without the busy pull-down.
- R5: After the outside lows end, the segment held last is released first. The other enabled segments stay driven until both shared lines are seen high.
- R6: The busy pull-down is released once the held line is high and either the last-held segment reads high or RISE_US × CYC_PER_US clock cycles have passed without it reading high.
- R7: Activity on SDA has no effect on the SCL outputs, and activity on SCL has no effect on the SDA outputs.
- R8: When another hub pulls the shared busy line low, every enabled segment is driven low. The segments are released once both shared lines are high, and this hub does not pull the shared lines itself.
- R9: After all outside lows and all remote shared-line lows end, every pull-down returns to released within a bounded number of cycles (no lock-up).
- R10: A device that stretches the clock on one segment keeps the clock driven low on the segment of a master that has already released it.
- R11: When two segments are held low at once, the one released last is tracked as the last holder, and it is released before the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | NPORT-1 | Enables for segments 1..NPORT-1 (bit i = segment i) |
| sda_in | input | NPORT | Per-segment SDA input, 0 = pulled low by an outside device |
| scl_in | input | NPORT | Per-segment SCL input, 0 = pulled low by an outside device |
| sda_pd | output | NPORT | Per-segment SDA pull-down, 1 = drive low |
| scl_pd | output | NPORT | Per-segment SCL pull-down, 1 = drive low |
| exp_sda_in | input | 2 | Sampled shared SDA lines, bit 0 busy, bit 1 held |
| exp_scl_in | input | 2 | Sampled shared SCL lines, bit 0 busy, bit 1 held |
| exp_sda_pd | output | 2 | Pull-downs for the shared SDA lines |
| exp_scl_pd | output | 2 | Pull-downs for the shared SCL lines |

## Verification
The bench builds the hub with five segments, CYC_PER_US = 8 and RISE_US = 1, so the rise timeout is eight cycles. That short window makes it practical to force the timeout path: the last-held segment is pulled low again just as its release starts, and the delay before the busy line falls is measured. Stand-in bits on the shared lines play the part of a second hub, which exercises cluster behaviour without a second instance. Release order and lock-up freedom are checked by recording the cycle at which each pull-down falls after a release.

// File: rtl/i2c_hub_rpt.sv
module i2c_hub_rpt #(
  parameter int NPORT      = 5,
  parameter int CYC_PER_US = 50,
  parameter int RISE_US    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:1] port_en,
  input  logic [NPORT-1:0] sda_in,
  input  logic [NPORT-1:0] scl_in,
  output logic [NPORT-1:0] sda_pd,
  output logic [NPORT-1:0] scl_pd,
  input  logic [1:0]       exp_sda_in,
  input  logic [1:0]       exp_scl_in,
  output logic [1:0]       exp_sda_pd,
  output logic [1:0]       exp_scl_pd
);
  localparam int RISE_CYC = CYC_PER_US * RISE_US;
  localparam int TW       = $clog2(RISE_CYC + 1);
  localparam int IW       = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [NPORT-1:0]      en_all;
  logic [1:0][NPORT-1:0] l_in;
  logic [1:0][NPORT-1:0] l_pd;
  logic [1:0][1:0]       x_in;
  logic [1:0][1:0]       x_pd;

  assign en_all     = {port_en, 1'b1};
  assign l_in       = {scl_in, sda_in};
  assign x_in       = {exp_scl_in, exp_sda_in};
  assign sda_pd     = l_pd[0];
  assign scl_pd     = l_pd[1];
  assign exp_sda_pd = x_pd[0];
  assign exp_scl_pd = x_pd[1];

  for (genvar g = 0; g < 2; g++) begin : g_line
    typedef enum logic [1:0] {PH_IDLE, PH_HOLD, PH_RISE} ph_e;
    ph_e              ph;
    logic [NPORT-1:0] s1, s2, ext, ext_n, last_oh;
    logic [1:0]       x1, x2;
    logic [IW-1:0]    last, last_n;
    logic [TW-1:0]    tmr;
    logic             rel_last, any_ext, busy_hi, held_hi, active;

    assign any_ext = |ext;
    assign busy_hi = x2[0];
    assign held_hi = x2[1];
    assign active  = any_ext | (ph != PH_IDLE);
    assign last_oh = NPORT'(1) << last;

    always_comb begin
      ext_n = en_all & ~s2;
      if (ph == PH_RISE) ext_n = ext_n & ~last_oh;
      last_n = last;
      for (int i = NPORT - 1; i >= 0; i--)
        if (ext_n[i]) last_n = IW'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1       <= '1;
        s2       <= '1;
        x1       <= '1;
        x2       <= '1;
        ext      <= '0;
        last     <= '0;
        tmr      <= '0;
        rel_last <= 1'b0;
        ph       <= PH_IDLE;
      end else begin
        s1   <= l_in[g] | ~en_all;
        s2   <= s1;
        x1   <= x_in[g];
        x2   <= x1;
        ext  <= ext_n;
        last <= last_n;
        case (ph)
          PH_IDLE: begin
            if (any_ext) begin
              ph       <= PH_HOLD;
              rel_last <= 1'b0;
            end else if (busy_hi && held_hi) begin
              rel_last <= 1'b0;
            end
          end
          PH_HOLD: begin
            if (!any_ext && held_hi) begin
              ph       <= PH_RISE;
              rel_last <= 1'b1;
              tmr      <= TW'(RISE_CYC);
            end
          end
          PH_RISE: begin
            if (any_ext) begin
              ph       <= PH_HOLD;
              rel_last <= 1'b0;
            end else if (((s2 & last_oh) != '0) || (tmr == '0)) begin
              ph <= PH_IDLE;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end

    assign x_pd[g] = {any_ext, active};
    assign l_pd[g] = en_all & {NPORT{~busy_hi | ~held_hi | active}}
                   & ~(rel_last ? last_oh : '0);
  end
endmodule

// File: rtl/i2c_hub_rpt_chk.sv
module i2c_hub_rpt_chk #(
  parameter int NPORT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:1] port_en,
  input logic [NPORT-1:0] sda_pd,
  input logic [NPORT-1:0] scl_pd,
  input logic [1:0]       exp_sda_in,
  input logic [1:0]       exp_scl_in,
  input logic [1:0]       exp_sda_pd,
  input logic [1:0]       exp_scl_pd
);
  logic [NPORT-1:0] en_all;
  assign en_all = {port_en, 1'b1};

  assert_dis_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pd | scl_pd) & ~en_all) == '0);

  assert_held_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exp_sda_pd[1] |-> exp_sda_pd[0]);

  assert_held_in_busy_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exp_scl_pd[1] |-> exp_scl_pd[0]);

  assert_remote_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(exp_sda_in[0], 2) && !$past(exp_sda_in[0], 3))
      |-> ($countones(en_all & ~sda_pd) <= 1));

  assert_no_lockup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_sda_pd == 2'b00 && $past(exp_sda_in, 2) == 2'b11) |-> (sda_pd == '0));

  assert_no_lockup_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_scl_pd == 2'b00 && $past(exp_scl_in, 2) == 2'b11) |-> (scl_pd == '0));
endmodule

bind i2c_hub_rpt i2c_hub_rpt_chk #(.NPORT(NPORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .sda_pd(sda_pd), .scl_pd(scl_pd),
  .exp_sda_in(exp_sda_in), .exp_scl_in(exp_scl_in),
  .exp_sda_pd(exp_sda_pd), .exp_scl_pd(exp_scl_pd));

// File: tb/i2c_hub_rpt_tb_top.sv
module i2c_hub_rpt_tb_top;
  localparam int NP   = 5;
  localparam int CPU  = 8;
  localparam int RISE = CPU;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:1] port_en = '1;
  logic [NP-1:0] dev_sda = '0, dev_scl = '0;
  logic [1:0]    rem_sda = '0, rem_scl = '0;
  logic [NP-1:0] sda_pd, scl_pd;
  logic [1:0]    exp_sda_pd, exp_scl_pd, exp_sda_in, exp_scl_in;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign exp_sda_in = ~(exp_sda_pd | rem_sda);
  assign exp_scl_in = ~(exp_scl_pd | rem_scl);

  i2c_hub_rpt #(.NPORT(NP), .CYC_PER_US(CPU), .RISE_US(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .sda_in(~dev_sda), .scl_in(~dev_scl),
    .sda_pd(sda_pd), .scl_pd(scl_pd),
    .exp_sda_in(exp_sda_in), .exp_scl_in(exp_scl_in),
    .exp_sda_pd(exp_sda_pd), .exp_scl_pd(exp_scl_pd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    int quiet = 0;
    int k = 0;
    while (quiet < 4 && k < 300) begin
      @(negedge clk);
      k++;
      if (sda_pd == '0 && scl_pd == '0 && exp_sda_pd == '0 && exp_scl_pd == '0) quiet++;
      else quiet = 0;
    end
    check(quiet >= 4, req, k, 0);
  endtask

  task automatic rel_track(input bit scl, input int lp,
                           output int t_held, output int t_busy,
                           output int t_last, output int t_oth);
    logic [NP-1:0] en_all, pdv, om;
    logic [1:0] xp;
    en_all = {port_en, 1'b1};
    om = en_all & ~(NP'(1) << lp);
    t_held = -1; t_busy = -1; t_last = -1; t_oth = -1;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      pdv = scl ? scl_pd : sda_pd;
      xp  = scl ? exp_scl_pd : exp_sda_pd;
      if (t_held < 0 && !xp[1]) t_held = k;
      if (t_busy < 0 && !xp[0]) t_busy = k;
      if (t_last < 0 && !pdv[lp]) t_last = k;
      if (t_oth < 0 && (pdv & om) == '0) t_oth = k;
    end
  endtask

  task automatic t_reset;
    check(sda_pd == '0 && scl_pd == '0, "R1 port pd", int'({sda_pd, scl_pd}), 0);
    check(exp_sda_pd == '0 && exp_scl_pd == '0, "R1 exp pd",
          int'({exp_sda_pd, exp_scl_pd}), 0);
  endtask

  task automatic t_basic;
    int th, tb, tl, to;
    dev_sda[0] = 1'b1;
    cyc(10);
    check(exp_sda_pd == 2'b11, "R2 exp pulled", exp_sda_pd, 3);
    check(sda_pd == 5'h1F, "R2 all ports driven", sda_pd, 31);
    check(scl_pd == '0 && exp_scl_pd == '0, "R7 scl untouched", scl_pd, 0);
    dev_sda[0] = 1'b0;
    rel_track(1'b0, 0, th, tb, tl, to);
    check(th >= 0 && th <= tb, "R4 held before busy", th, tb);
    check(tl >= 0 && tl < to, "R5 last released first", tl, to);
    check(tb >= 0 && tb < to, "R5 others after busy", tb, to);
    check(tb - tl < RISE, "R6 early release on high", tb - tl, RISE);
    wait_idle("R9 idle after basic");
  endtask

  task automatic t_disable;
    port_en = 4'b1011;
    cyc(4);
    dev_sda[3] = 1'b1;
    cyc(12);
    check(exp_sda_pd == '0 && sda_pd == '0, "R3 disabled input ignored",
          int'({exp_sda_pd, sda_pd}), 0);
    dev_sda[3] = 1'b0;
    dev_sda[0] = 1'b1;
    cyc(12);
    check(sda_pd == 5'b10111, "R3 disabled not driven", sda_pd, 23);
    dev_sda[0] = 1'b0;
    wait_idle("R3 idle");
    port_en = 4'b1111;
    cyc(4);
  endtask

  task automatic t_stretch;
    int th, tb, tl, to;
    dev_scl[0] = 1'b1;
    cyc(10);
    dev_scl[2] = 1'b1;
    cyc(5);
    dev_scl[0] = 1'b0;
    cyc(12);
    check(scl_pd[0] == 1'b1, "R10 master segment held", scl_pd[0], 1);
    check(exp_scl_pd == 2'b11, "R10 exp still low", exp_scl_pd, 3);
    check(sda_pd == '0 && exp_sda_pd == '0, "R7 sda untouched", sda_pd, 0);
    dev_scl[2] = 1'b0;
    rel_track(1'b1, 2, th, tb, tl, to);
    check(tl >= 0 && tl < to, "R10 stretcher released first", tl, to);
    wait_idle("R9 idle after stretch");
  endtask

  task automatic t_arb;
    int th, tb, tl, to;
    dev_sda[1] = 1'b1;
    dev_sda[4] = 1'b1;
    cyc(10);
    dev_sda[4] = 1'b0;
    cyc(10);
    check(sda_pd[4] == 1'b1 && exp_sda_pd[1] == 1'b1, "R11 first release still driven",
          int'({sda_pd[4], exp_sda_pd[1]}), 3);
    dev_sda[1] = 1'b0;
    rel_track(1'b0, 1, th, tb, tl, to);
    check(tl >= 0 && tl < to, "R11 last holder released first", tl, to);
    check(th >= 0 && th <= tb, "R4 held then busy", th, tb);
    wait_idle("R9 idle after arb");
  endtask

  task automatic t_timeout;
    int k = 0, t_l = -1, t_b = -1;
    dev_sda[0] = 1'b1;
    cyc(10);
    dev_sda[0] = 1'b0;
    while (exp_sda_pd[1] && k < 50) begin
      @(negedge clk);
      k++;
    end
    @(posedge clk);
    @(negedge clk);
    dev_sda[0] = 1'b1;
    for (int j = 0; j < 60; j++) begin
      @(negedge clk);
      if (t_l < 0 && !sda_pd[0]) t_l = j;
      if (t_l >= 0 && t_b < 0 && !exp_sda_pd[0]) t_b = j;
    end
    check(t_l >= 0 && t_b >= 0 && (t_b - t_l) >= RISE && (t_b - t_l) <= RISE + 2,
          "R6 rise timeout", t_b - t_l, RISE + 1);
    check(exp_sda_pd[0] == 1'b1, "R2 low after timeout re-held", exp_sda_pd[0], 1);
    dev_sda[0] = 1'b0;
    wait_idle("R9 idle after timeout");
  endtask

  task automatic t_remote;
    rem_sda = 2'b11;
    cyc(8);
    check(sda_pd == 5'h1F, "R8 remote drives ports", sda_pd, 31);
    check(exp_sda_pd == '0, "R8 no own exp drive", exp_sda_pd, 0);
    rem_sda[1] = 1'b0;
    cyc(6);
    check(sda_pd == 5'h1F, "R8 busy still low", sda_pd, 31);
    rem_sda[0] = 1'b0;
    cyc(6);
    check(sda_pd == '0, "R8 released", sda_pd, 0);
    wait_idle("R9 idle after remote");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_basic();
    t_disable();
    t_stretch();
    t_arb();
    t_timeout();
    t_remote();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule